// File: doc/BRIEF.md
# Bus Remote Wakeup Pattern Detector

This block watches the classified symbol stream from a bus receiver while the node sleeps and decides whether another node is asking it to wake. Every clock cycle one symbol code arrives (Data_0, Data_1 or Idle). The detector looks for a wakeup pattern made of two Data_0 phases, each one followed by a separator phase of Idle or Data_1. Each phase must last at least a minimum number of cycles, and the whole pattern must complete inside a bounded window. A short burst of the opposite symbol class inside a phase is absorbed rather than treated as the end of that phase.

Phase tracking keeps running in normal-power operation, so a pattern that starts before the node drops into a low-power mode still counts once it completes there. A detected pattern sets a sticky remote-wakeup flag and fires a one-cycle pulse for the mode controller. The flag is cleared on each entry into a low-power mode. A missing battery supply discards all tracking. Every duration is a parameter counted in clock cycles.

Top module: `remote_wake_detect`

## Requirements
- R1: The symbol code 2'b10 is Data_0. The codes 2'b00 (Idle), 2'b01 (Data_1) and 2'b11 are all separators and are treated the same way.
- R2: A Data_0 phase of at least D0_DET_CYC cycles, then a separator phase of at least SEP_DET_CYC cycles, then a second Data_0 phase of at least D0_DET_CYC cycles, then a separator, is a wakeup. wakeFlag and wakePulse rise at the clock edge that samples the SEP_DET_CYC-th symbol of the second separator phase.
- R3: If any of the first three phases is shorter than its minimum, that attempt is abandoned. A later Data_0 phase may start a fresh attempt.
- R4: Count N cycles from the first symbol of the first Data_0 phase through the completing separator symbol. The pattern is accepted when N <= TIMEOUT_CYC and rejected when N > TIMEOUT_CYC.
- R5: A run of fewer than INTR_CYC symbols of the other class inside a phase does not end that phase, and those cycles count toward its length. A phase can only qualify on a symbol of its own class. A run of INTR_CYC or more such symbols starts a new phase, whose length is counted from the first symbol of that run.
- R6: When the window expires while a Data_0 phase is in progress, that Data_0 phase becomes the first phase of a new attempt, timed from its own first symbol.
- R7: A wakeup is reported only when lowPower and vbatOk are both high at the completing edge. While vbatOk is low, all phase and pattern tracking is discarded.
- R8: Phases that qualified while lowPower was low still count towards a pattern that completes after lowPower has risen.
- R9: wakeFlag stays set, including after lowPower falls, until the first clock edge at which lowPower is sampled high after being sampled low. That edge clears it, and the clear overrides a coincident detection.
- R10: wakePulse is high for exactly one cycle, and only when wakeFlag goes from 0 to 1. A further detection while the flag is already set gives no pulse.
- R11: After reset, wakeFlag and wakePulse are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| symIn | input | 2 | Classified bus symbol, one per cycle |
| lowPower | input | 1 | High while the node is in a low-power mode |
| vbatOk | input | 1 | High while the battery supply is valid |
| wakeFlag | output | 1 | Sticky remote-wakeup flag |
| wakePulse | output | 1 | One-cycle pulse when the flag sets |

## Verification
Both outputs are registered straight from the same edge that samples the completing symbol. After the bench drives its k-th symbol of a trial and the next rising edge, the outputs must already show the decision for symbol k, and the bench compares them at that point after every symbol. For each trial the bench computes, from the phase lengths it drives, the exact step N at which the flag must rise, or decides that it must never rise. At every step it then checks that the flag is low before N, that the pulse is high only at N, and that the flag stays high after N. A lowPower entry clears the flag on the first edge that sees lowPower high, so the clear is checked one sample after lowPower is raised.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

  // Filtered level of the bus: the current phase is either Data_0 or a separator
  typedef enum logic {
    LVL_SEP = 1'b0,
    LVL_D0  = 1'b1
  } wkLevel_e;

  // Strobes sent from the sequence control to the phase datapath
  typedef struct packed {
    logic clear;      // drop all phase and timer state
    logic timerSync;  // load pattern timer from the current phase length
    logic timerRun;   // advance pattern timer by one
  } wkStrobe_t;

  function automatic logic isData0(input logic [1:0] code);
    return code == 2'b10;
  endfunction

endpackage

// File: rtl/wkp_phase_path.sv
module wkp_phase_path
  import wkp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int INTR_CYC    = 3,
  parameter int TIMEOUT_CYC = 80
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       symIn,
  input  wkStrobe_t        strobe,
  output wkLevel_e         nLvl,
  output logic [CNT_W-1:0] nPhaseCnt,
  output logic             phaseFlip,
  output logic             onPhase,
  output logic             timerOver
);

  localparam int GL_W = (INTR_CYC < 2) ? 1 : $clog2(INTR_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] INTR_V  = CNT_W'(INTR_CYC);
  localparam logic [CNT_W-1:0] TMO_V   = CNT_W'(TIMEOUT_CYC);
  localparam logic [GL_W-1:0]  GL_LAST = GL_W'(INTR_CYC - 1);

  wkLevel_e         lvl;
  wkLevel_e         symLvl;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] timer;
  logic [GL_W-1:0]  glitchCnt;
  logic [GL_W-1:0]  nGlitch;

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  assign symLvl = isData0(symIn) ? LVL_D0 : LVL_SEP;

  // Interruption filter: the phase only changes after INTR_CYC other-class symbols
  always_comb begin
    nLvl      = lvl;
    nPhaseCnt = satInc(phaseCnt);
    nGlitch   = '0;
    phaseFlip = 1'b0;
    if (symLvl != lvl) begin
      if (glitchCnt == GL_LAST) begin
        phaseFlip = 1'b1;
        nLvl      = symLvl;
        nPhaseCnt = INTR_V;
      end else begin
        nGlitch = glitchCnt + 1'b1;
      end
    end
  end

  assign onPhase   = (symLvl == nLvl);
  assign timerOver = (timer >= TMO_V);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvl       <= LVL_SEP;
      phaseCnt  <= '0;
      glitchCnt <= '0;
      timer     <= '0;
    end else if (strobe.clear) begin
      lvl       <= LVL_SEP;
      phaseCnt  <= '0;
      glitchCnt <= '0;
      timer     <= '0;
    end else begin
      lvl       <= nLvl;
      phaseCnt  <= nPhaseCnt;
      glitchCnt <= nGlitch;
      if (strobe.timerSync) begin
        timer <= (nLvl == LVL_D0) ? nPhaseCnt : '0;
      end else if (strobe.timerRun) begin
        timer <= satInc(timer);
      end
    end
  end

endmodule

// File: rtl/wkp_seq_ctrl.sv
module wkp_seq_ctrl
  import wkp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int D0_DET_CYC  = 12,
  parameter int SEP_DET_CYC = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lowPower,
  input  logic             vbatOk,
  input  wkLevel_e         nLvl,
  input  logic [CNT_W-1:0] nPhaseCnt,
  input  logic             phaseFlip,
  input  logic             onPhase,
  input  logic             timerOver,
  output wkStrobe_t        strobe,
  output logic             wakeFlag,
  output logic             wakePulse
);

  localparam logic [CNT_W-1:0] D0_THR  = CNT_W'(D0_DET_CYC);
  localparam logic [CNT_W-1:0] SEP_THR = CNT_W'(SEP_DET_CYC);

  // qualCnt: number of qualified phases of the current attempt (0..3)
  logic [1:0]       qualCnt, nQual;
  logic             curQual, nCurQual;
  logic             abort, detect, wantD0, lowPrev, entry, setFlag;
  logic [CNT_W-1:0] thr;

  always_comb begin
    nQual    = qualCnt;
    nCurQual = curQual;
    abort    = 1'b0;
    detect   = 1'b0;
    // a phase that ends before qualifying breaks the attempt
    if (phaseFlip) begin
      nCurQual = 1'b0;
      if (!curQual) nQual = 2'd0;
    end
    // window expired: a qualified Data_0 in progress is kept as first phase
    if (qualCnt != 2'd0 && timerOver) begin
      abort = 1'b1;
      nQual = (nLvl == LVL_D0 && nCurQual) ? 2'd1 : 2'd0;
    end
    thr    = (nLvl == LVL_D0) ? D0_THR : SEP_THR;
    wantD0 = ~nQual[0];
    if (!nCurQual && onPhase && nPhaseCnt >= thr && ((nLvl == LVL_D0) == wantD0)) begin
      nCurQual = 1'b1;
      if (nQual == 2'd3) begin
        detect = 1'b1;
        nQual  = 2'd0;
      end else begin
        nQual = nQual + 2'd1;
      end
    end
    if (!vbatOk) begin
      nQual    = 2'd0;
      nCurQual = 1'b0;
      abort    = 1'b0;
      detect   = 1'b0;
    end
  end

  always_comb begin
    strobe.clear     = !vbatOk;
    strobe.timerSync = (nQual == 2'd0) || abort;
    strobe.timerRun  = !strobe.timerSync;
  end

  assign entry   = lowPower && !lowPrev;
  assign setFlag = detect && lowPower && vbatOk && !entry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCnt   <= 2'd0;
      curQual   <= 1'b0;
      lowPrev   <= 1'b0;
      wakeFlag  <= 1'b0;
      wakePulse <= 1'b0;
    end else begin
      qualCnt   <= nQual;
      curQual   <= nCurQual;
      lowPrev   <= lowPower;
      wakePulse <= setFlag && !wakeFlag;
      if (entry) begin
        wakeFlag <= 1'b0;
      end else if (setFlag) begin
        wakeFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/remote_wake_detect.sv
module remote_wake_detect
  import wkp_pkg::*;
#(
  parameter int D0_DET_CYC  = 12,
  parameter int SEP_DET_CYC = 12,
  parameter int TIMEOUT_CYC = 80,
  parameter int INTR_CYC    = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] symIn,
  input  logic       lowPower,
  input  logic       vbatOk,
  output logic       wakeFlag,
  output logic       wakePulse
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 2) + 1;

  wkStrobe_t        strobe;
  wkLevel_e         nLvl;
  logic [CNT_W-1:0] nPhaseCnt;
  logic             phaseFlip;
  logic             onPhase;
  logic             timerOver;

  wkp_phase_path #(
    .CNT_W      (CNT_W),
    .INTR_CYC   (INTR_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .symIn    (symIn),
    .strobe   (strobe),
    .nLvl     (nLvl),
    .nPhaseCnt(nPhaseCnt),
    .phaseFlip(phaseFlip),
    .onPhase  (onPhase),
    .timerOver(timerOver)
  );

  wkp_seq_ctrl #(
    .CNT_W      (CNT_W),
    .D0_DET_CYC (D0_DET_CYC),
    .SEP_DET_CYC(SEP_DET_CYC)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lowPower (lowPower),
    .vbatOk   (vbatOk),
    .nLvl     (nLvl),
    .nPhaseCnt(nPhaseCnt),
    .phaseFlip(phaseFlip),
    .onPhase  (onPhase),
    .timerOver(timerOver),
    .strobe   (strobe),
    .wakeFlag (wakeFlag),
    .wakePulse(wakePulse)
  );

endmodule

// File: rtl/remote_wake_detect_chk.sv
module remote_wake_detect_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] symIn,
  input logic       lowPower,
  input logic       vbatOk,
  input logic       wakeFlag,
  input logic       wakePulse
);

  AST_WAKE_NEEDS_LP: assert property (@(posedge clk) disable iff (!rstN)
    !(lowPower && vbatOk) |=> !wakePulse); // R7

  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowPower) |=> !wakeFlag); // R9

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (wakeFlag && !$rose(lowPower)) |=> wakeFlag); // R9

  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> $rose(wakeFlag)); // R10

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse); // R10

  AST_RISE_HAS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> wakePulse); // R10

  always_comb begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!wakeFlag && !wakePulse); // R11
    end
  end

endmodule

bind remote_wake_detect remote_wake_detect_chk i_chk (.*);

// File: tb/test_remote_wake_detect.sv
module test_remote_wake_detect;

  localparam int D0D = 12;
  localparam int SPD = 12;
  localparam int TMO = 80;
  localparam int ITR = 3;
  localparam logic [1:0] C_D0 = 2'b10;
  localparam logic [1:0] C_ID = 2'b00;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] symIn = 2'b00;
  logic       lowPower = 1'b1;
  logic       vbatOk = 1'b1;
  logic       wakeFlag;
  logic       wakePulse;

  int nTests = 0;
  int nFail  = 0;
  int stepIdx = 0;
  int expN = 0;
  bit flagInit = 1'b0;
  bit checking = 1'b0;
  bit trialBad = 1'b0;
  int badStep = 0;
  logic badF, badP, badEF, badEP;

  always #4 clk = ~clk;

  remote_wake_detect #(
    .D0_DET_CYC (D0D),
    .SEP_DET_CYC(SPD),
    .TIMEOUT_CYC(TMO),
    .INTR_CYC   (ITR)
  ) i_remote_wake_detect (
    .clk      (clk),
    .rstN     (rstN),
    .symIn    (symIn),
    .lowPower (lowPower),
    .vbatOk   (vbatOk),
    .wakeFlag (wakeFlag),
    .wakePulse(wakePulse)
  );

  task automatic step(input logic [1:0] code);
    logic ef, ep;
    symIn = code;
    @(posedge clk);
    #2;
    stepIdx++;
    ef = flagInit || (expN != 0 && stepIdx >= expN);
    ep = !flagInit && expN != 0 && stepIdx == expN;
    if (checking && !trialBad && (wakeFlag !== ef || wakePulse !== ep)) begin
      trialBad = 1'b1;
      badStep  = stepIdx;
      badF = wakeFlag; badP = wakePulse; badEF = ef; badEP = ep;
    end
  endtask

  task automatic seg(input logic [1:0] code, input int len);
    for (int i = 0; i < len; i++) step(code);
  endtask

  task automatic startTrial(input int n);
    checking = 1'b0;
    lowPower = 1'b0;
    vbatOk   = 1'b0;
    step(C_ID);
    vbatOk   = 1'b1;
    lowPower = 1'b1;
    step(C_ID);
    stepIdx  = 0;
    flagInit = 1'b0;
    trialBad = 1'b0;
    expN     = n;
    checking = 1'b1;
  endtask

  task automatic endTrial(input string req, input string what);
    nTests++;
    checking = 1'b0;
    if (trialBad) begin
      nFail++;
      $display("FAIL %s %s: step %0d flag=%0b pulse=%0b expected flag=%0b pulse=%0b",
               req, what, badStep, badF, badP, badEF, badEP);
    end
  endtask

  task automatic checkBit(input string req, input string what, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] sepCode(input int k);
    case (k % 3)
      0:       return 2'b00;
      1:       return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    nTests++;
    nFail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int lenA[3];
    int lenB[3];
    int idx;
    lenA = '{D0D - 1, D0D, D0D + 7};
    lenB = '{SPD - 1, SPD, SPD + 9};
    idx = 0;

    // R11: reset state, during and just after reset
    repeat (3) @(posedge clk);
    #2;
    checkBit("R11", "flag in reset", wakeFlag, 1'b0);
    checkBit("R11", "pulse in reset", wakePulse, 1'b0);
    rstN = 1'b1;
    step(C_ID);
    step(C_ID);
    checkBit("R11", "flag after reset", wakeFlag, 1'b0);
    checkBit("R11", "pulse after reset", wakePulse, 1'b0);

    // R1 R2 R3: sweep of phase lengths around the minimums, separator code rotated
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        for (int c = 0; c < 3; c++) begin
          int n;
          bit ok;
          logic [1:0] sc;
          n  = lenA[a] + lenB[b] + lenA[c] + SPD;
          ok = lenA[a] >= D0D && lenB[b] >= SPD && lenA[c] >= D0D && n <= TMO;
          sc = sepCode(idx);
          idx++;
          startTrial(ok ? n : 0);
          seg(C_D0, lenA[a]);
          seg(sc, lenB[b]);
          seg(C_D0, lenA[c]);
          seg(sc, SPD + 8);
          endTrial(ok ? "R2" : "R3", $sformatf("sweep d0=%0d sep=%0d d0=%0d code=%0d",
                   lenA[a], lenB[b], lenA[c], sc));
        end
      end
    end

    // R4: window boundary, N == TMO accepted
    startTrial(TMO);
    seg(C_D0, D0D); seg(C_ID, TMO - 2 * D0D - SPD); seg(C_D0, D0D); seg(C_ID, SPD + 8);
    endTrial("R4", "duration equal to window");

    // R4: N == TMO + 1 rejected
    startTrial(0);
    seg(C_D0, D0D); seg(2'b01, TMO - 2 * D0D - SPD + 1); seg(C_D0, D0D); seg(2'b01, SPD + 8);
    endTrial("R4", "duration one over window");

    // R6: window expires inside second Data_0, which restarts the attempt
    startTrial(72 + 4 * 12);
    seg(C_D0, 12); seg(C_ID, 60); seg(C_D0, 12); seg(C_ID, 12); seg(C_D0, 12); seg(C_ID, 20);
    endTrial("R6", "timeout reuses Data_0 in progress");

    // R5: short interruption inside Data_0 absorbed and counted
    startTrial(14 + 14 + 12 + 12);
    seg(C_D0, 6); seg(C_ID, ITR - 1); seg(C_D0, 6); seg(C_ID, 14); seg(C_D0, 12); seg(C_ID, 20);
    endTrial("R5", "short gap inside Data_0");

    // R5: short Data_0 blip inside a separator absorbed and counted
    startTrial(12 + 14 + 12 + 12);
    seg(C_D0, 12); seg(2'b01, 6); seg(C_D0, ITR - 1); seg(2'b01, 6); seg(C_D0, 12); seg(C_ID, 20);
    endTrial("R5", "short blip inside separator");

    // R5: interruption of INTR cycles splits Data_0 into two short phases
    startTrial(0);
    seg(C_D0, 6); seg(C_ID, ITR); seg(C_D0, 6); seg(C_ID, 14); seg(C_D0, 14); seg(C_ID, 20);
    endTrial("R5", "long gap ends Data_0");

    // R5: Data_0 run of INTR cycles cuts the separator short
    startTrial(0);
    seg(C_D0, 12); seg(C_ID, 6); seg(C_D0, ITR); seg(C_ID, 6); seg(C_D0, 12); seg(C_ID, 20);
    endTrial("R5", "long blip ends separator");

    // R8: pattern begun in normal power completes after low-power entry
    startTrial(12 + 14 + 12 + 12);
    lowPower = 1'b0;
    seg(C_D0, 12); seg(C_ID, 14);
    lowPower = 1'b1;
    seg(C_D0, 12); seg(C_ID, 20);
    endTrial("R8", "started in normal power");

    // R7: pattern completed entirely in normal power never reported
    startTrial(0);
    lowPower = 1'b0;
    seg(C_D0, 12); seg(C_ID, 14); seg(C_D0, 12); seg(C_ID, 20);
    lowPower = 1'b1;
    seg(C_ID, 5);
    endTrial("R7", "completed in normal power");

    // R7: one cycle of missing supply discards the tracked separator
    startTrial(0);
    seg(C_D0, 12); seg(C_ID, 5);
    vbatOk = 1'b0;
    step(C_ID);
    vbatOk = 1'b1;
    seg(C_ID, 10); seg(C_D0, 12); seg(C_ID, 20);
    endTrial("R7", "supply drop mid pattern");

    // R9 R10: flag sticky, second detection gives no pulse, cleared on entry
    startTrial(50);
    seg(C_D0, 12); seg(C_ID, 14); seg(C_D0, 12); seg(C_ID, 20);
    endTrial("R2", "first detection");
    flagInit = 1'b1;
    expN     = 0;
    trialBad = 1'b0;
    checking = 1'b1;
    seg(C_D0, 12); seg(C_ID, 14); seg(C_D0, 12); seg(C_ID, 20);
    endTrial("R10", "second detection while flag set");
    lowPower = 1'b0;
    seg(C_ID, 3);
    checkBit("R9", "flag held after leaving low power", wakeFlag, 1'b1);
    checkBit("R10", "no pulse while held", wakePulse, 1'b0);
    lowPower = 1'b1;
    step(C_ID);
    checkBit("R9", "flag cleared on entry", wakeFlag, 1'b0);
    seg(C_ID, 3);
    checkBit("R9", "flag stays clear", wakeFlag, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule